// File: doc/BRIEF.md
# Polled I2C Master Byte Engine

This block is a single-master I2C controller that software steps through a transfer one bus event at a time. A small register window carries a data byte, a control byte, a bit-rate byte and a status byte. Software asks for a START, loads an address or data byte, or asks for a STOP. The engine performs that one event on the open-drain SCL and SDA lines, reports a numeric code for its outcome, raises an event flag and then parks the bus with SCL held low. It does nothing further until software clears the flag.

The bit rate comes from two fields, a mantissa M and an exponent N. One quarter of an SCL period lasts Q = 5·(M+1)·2^N core clocks, which gives an SCL period of 10·(M+1)·2^(N+1) clocks. With M=9 and N=3 the bus runs near 100 kHz from a 160 MHz core clock. The first byte after a START or a repeated START is treated as an address, and its bit 0 selects the direction of the bytes that follow. A write to the soft-reset address releases the bus and returns the engine to idle at once.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, the event flag (`irq`) is 0, both bus lines are released, and the control, data and bit-rate registers read 0.
- R2: The bit-rate register (write and read address 2 and 3) holds M in bits [6:3] and N in bits [2:0]. A START completes 1+4·Q cycles after the write that requests it, and a byte with its acknowledge bit completes 1+36·Q cycles after the write that clears the flag, where Q = 5·(M+1)·2^N.
- R3: The control register at address 1 uses bit 0 for enable, bit 1 for start, bit 2 for stop, bit 3 for the event flag and bit 4 for acknowledge. With enable set, a start request from idle produces a START condition, status 0x08 and the flag, and the start bit reads 0 afterwards.
- R4: A start request made while the flag is set produces a repeated START once the flag is cleared, and reports status 0x10.
- R5: An address byte (data register, address 0) with bit 0 = 0 reports 0x18 when the slave acknowledges and 0x20 when it does not.
- R6: An address byte with bit 0 = 1 reports 0x40 when the slave acknowledges and 0x48 when it does not.
- R7: In write direction a data byte is shifted out MSB first and reports 0x28 on acknowledge and 0x30 on no-acknowledge.
- R8: In read direction a byte is received into the data register. With the acknowledge bit at 1 the master acknowledges and reports 0x50; with it at 0 the master returns a NACK and reports 0x58.
- R9: While the flag is set, SCL is held low and the status stays unchanged however long software waits. Writing 1 to the flag bit never sets it.
- R10: A stop request (with the flag cleared) produces a STOP condition. Status 0xF8 appears 1+4·Q cycles after the request, and the stop bit and the flag then read 0 with both lines released.
- R11: A write to address 3 returns the engine to idle by the next edge: status 0xF8, control register 0, flag 0, both lines released.
- R12: A start request while enable is 0 has no effect on the bus, the status or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 2 bit rate, 3 soft reset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 data, 1 control, 2 status, 3 bit rate |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Event flag; high while the engine waits for software |
| scl_drive_low | output | 1 | Pull SCL low when 1; release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1; release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
Every result is due a fixed number of edges after the write that launches it. The flag rises 1+4·Q edges after a start request, and 1+36·Q edges after a flag-clearing write that launches a byte. Status 0xF8 follows a stop request by 1+4·Q edges, and the soft-reset effects are visible after the very next edge. The bench counts edges from the launching write to the observed change and compares that count with the formula for two bit-rate settings. Register reads are taken half a clock after an edge, so each value is compared once it has settled and before the next edge.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       sda_in
);
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_AW_NAK = 8'h20;
  localparam logic [7:0] ST_TX_ACK = 8'h28;
  localparam logic [7:0] ST_TX_NAK = 8'h30;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_AR_NAK = 8'h48;
  localparam logic [7:0] ST_RX_ACK = 8'h50;
  localparam logic [7:0] ST_RX_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_STA, S_XFER, S_HOLD, S_STO} st_t;

  st_t              state;
  logic             c_en, c_sta, c_sto, c_flg, c_ack;
  logic [7:0]       data_q, stat_q, sh;
  logic [3:0]       baud_m;
  logic [2:0]       baud_n;
  logic [1:0]       ph;
  logic [3:0]       bitc;
  logic             txm, addr_ph, rd_mode, got_ack, owned;
  logic [DIV_W-1:0] div_cnt, m_ext, quarter_len;
  logic             tick, soft_rst;

  assign m_ext       = DIV_W'(baud_m) + DIV_W'(1);
  assign quarter_len = (m_ext * DIV_W'(5)) << baud_n;
  assign tick        = (div_cnt == quarter_len - DIV_W'(1));
  assign soft_rst    = wr_en && (wr_addr == 2'd3);
  assign irq         = c_flg;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = data_q;
      2'd1:    rd_data = {3'b000, c_ack, c_flg, c_sto, c_sta, c_en};
      2'd2:    rd_data = stat_q;
      default: rd_data = {1'b0, baud_m, baud_n};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {c_en, c_sta, c_sto, c_flg, c_ack} <= '0;
      data_q <= '0;
      stat_q <= ST_IDLE;
      sh <= '0;
      baud_m <= '0;
      baud_n <= '0;
      ph <= '0;
      bitc <= '0;
      {txm, addr_ph, rd_mode, got_ack, owned} <= '0;
      div_cnt <= '0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: data_q <= wr_data;
          2'd1: begin
            c_en  <= wr_data[0];
            c_sta <= wr_data[1];
            c_sto <= wr_data[2];
            c_flg <= c_flg & wr_data[3];
            c_ack <= wr_data[4];
          end
          2'd2: begin
            baud_n <= wr_data[2:0];
            baud_m <= wr_data[6:3];
          end
          default: ;
        endcase
      end

      if (soft_rst) begin
        state <= S_IDLE;
        {c_en, c_sta, c_sto, c_flg, c_ack} <= '0;
        stat_q <= ST_IDLE;
        owned <= 1'b0;
        div_cnt <= '0;
        ph <= '0;
        scl_drive_low <= 1'b0;
        sda_drive_low <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            div_cnt <= '0;
            ph <= '0;
            if (c_en && c_sta) state <= S_STA;
          end
          S_HOLD: begin
            div_cnt <= '0;
            ph <= '0;
            if (!c_flg) begin
              if (c_sta)      state <= S_STA;
              else if (c_sto) state <= S_STO;
              else begin
                state <= S_XFER;
                bitc  <= '0;
                sh    <= data_q;
                txm   <= addr_ph || !rd_mode;
                if (addr_ph) rd_mode <= data_q[0];
              end
            end
          end
          default: begin
            if (!tick) begin
              div_cnt <= div_cnt + DIV_W'(1);
            end else begin
              div_cnt <= '0;
              ph <= ph + 2'd1;
              case (state)
                S_STA: begin
                  case (ph)
                    2'd0: sda_drive_low <= 1'b0;
                    2'd1: scl_drive_low <= 1'b0;
                    2'd2: sda_drive_low <= 1'b1;
                    default: begin
                      scl_drive_low <= 1'b1;
                      c_sta   <= 1'b0;
                      c_flg   <= 1'b1;
                      stat_q  <= owned ? ST_RSTART : ST_START;
                      owned   <= 1'b1;
                      addr_ph <= 1'b1;
                      state   <= S_HOLD;
                    end
                  endcase
                end
                S_XFER: begin
                  case (ph)
                    2'd0: begin
                      if (bitc == 4'd8) sda_drive_low <= txm ? 1'b0 : c_ack;
                      else              sda_drive_low <= txm ? ~sh[7] : 1'b0;
                    end
                    2'd1: scl_drive_low <= 1'b0;
                    2'd2: begin
                      if (bitc == 4'd8) got_ack <= ~sda_in;
                      else              sh <= {sh[6:0], sda_in};
                    end
                    default: begin
                      scl_drive_low <= 1'b1;
                      if (bitc != 4'd8) begin
                        bitc <= bitc + 4'd1;
                      end else begin
                        c_flg   <= 1'b1;
                        state   <= S_HOLD;
                        addr_ph <= 1'b0;
                        if (!txm) data_q <= sh;
                        if (addr_ph)
                          stat_q <= got_ack ? (rd_mode ? ST_AR_ACK : ST_AW_ACK)
                                            : (rd_mode ? ST_AR_NAK : ST_AW_NAK);
                        else if (txm)
                          stat_q <= got_ack ? ST_TX_ACK : ST_TX_NAK;
                        else
                          stat_q <= c_ack ? ST_RX_ACK : ST_RX_NAK;
                      end
                    end
                  endcase
                end
                default: begin
                  case (ph)
                    2'd0: sda_drive_low <= 1'b1;
                    2'd1: scl_drive_low <= 1'b0;
                    2'd2: sda_drive_low <= 1'b0;
                    default: begin
                      state  <= S_IDLE;
                      c_sto  <= 1'b0;
                      c_flg  <= 1'b0;
                      stat_q <= ST_IDLE;
                      owned  <= 1'b0;
                    end
                  endcase
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       irq,
  input logic       scl_lo,
  input logic       sda_lo,
  input logic [7:0] stat
);
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_lo); // R9
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> (stat == 8'hF8 && !irq && !scl_lo && !sda_lo)); // R11
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat == 8'hF8) |-> (!scl_lo && !sda_lo && !irq)); // R10
  AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat != 8'hF8)); // R3
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .irq(irq),
  .scl_lo(scl_drive_low), .sda_lo(sda_drive_low), .stat(stat_q)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/100ps
module sim_i2c_byte_master;
  localparam logic [7:0] EN = 8'h01, STA = 8'h02, STO = 8'h04, FLG = 8'h08, ACK = 8'h10;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd2;
  logic [7:0] wr_data = '0, rd_data;
  logic irq, scl_drive_low, sda_drive_low;
  logic sda_w, scl_w;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_w)
  );

  // open-drain bus with a small memory slave
  logic s_drv = 1'b0;
  assign sda_w = ~(sda_drive_low | s_drv);
  assign scl_w = ~scl_drive_low;

  logic [7:0] mem [4];
  logic [7:0] s_sh, s_tx;
  logic [1:0] ptr;
  int   bitn = 0;
  bit   s_act = 0, is_addr = 0, s_rd = 0, a_ok = 0, first = 0, txon = 0, m_ack = 0;
  bit   slv_ack_data = 1;

  always @(negedge sda_w) if (scl_w) begin
    s_act = 1; bitn = 0; is_addr = 1; s_drv = 0; txon = 0;
  end
  always @(posedge sda_w) if (scl_w) begin
    s_act = 0; s_drv = 0; txon = 0;
  end
  always @(posedge scl_w) if (s_act) begin
    if (bitn < 8) begin s_sh = {s_sh[6:0], sda_w}; bitn++; end
    else if (bitn == 8) begin m_ack = !sda_w; bitn = 9; end
  end
  always @(negedge scl_w) if (s_act) begin
    if (bitn == 8) begin
      if (is_addr) begin
        a_ok = (s_sh[7:1] == SLV); s_rd = s_sh[0]; s_drv = a_ok;
      end else if (!s_rd) begin
        s_drv = slv_ack_data;
        if (slv_ack_data) begin
          if (first) begin ptr = s_sh[1:0]; first = 0; end
          else begin mem[ptr] = s_sh; ptr++; end
        end
      end else s_drv = 0;
    end else if (bitn == 9) begin
      s_drv = 0; bitn = 0;
      if (is_addr) begin
        if (!a_ok) s_act = 0;
        else begin
          is_addr = 0; first = !s_rd;
          if (s_rd) begin txon = 1; s_tx = mem[ptr]; ptr++; s_drv = !s_tx[7]; end
        end
      end else if (s_rd && txon) begin
        if (m_ack) begin s_tx = mem[ptr]; ptr++; s_drv = !s_tx[7]; end
        else txon = 0;
      end
    end else if (bitn >= 1 && bitn <= 7 && txon) s_drv = !s_tx[7-bitn];
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #0.5; wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (irq !== 1'b1 && n < 20000) begin @(posedge clk); #0.5; n++; end
  endtask

  task automatic wait_idle(output int n);
    n = 0; rd_addr = 2; #0.1;
    while (rd_data !== 8'hF8 && n < 20000) begin @(posedge clk); #0.5; n++; end
  endtask

  task automatic ev_start(input int q, input logic [7:0] exp, input string r);
    int n; logic [7:0] v;
    wr(1, EN | STA); wait_irq(n);
    chk(r, "start cycles", n, 1 + 4*q);
    rd(2, v); chk(r, "start status", v, exp);
    rd(1, v); chk(r, "start bit cleared", v[1], 0);
  endtask

  task automatic ev_byte(input logic [7:0] d, input logic [7:0] c, input int q,
                         input logic [7:0] exp, input string r);
    int n; logic [7:0] v;
    wr(0, d); wr(1, c); wait_irq(n);
    chk(r, "byte cycles", n, 1 + 36*q);
    rd(2, v); chk(r, "byte status", v, exp);
  endtask

  task automatic ev_stop(input int q, input string r);
    int n; logic [7:0] v;
    wr(1, EN | STO); wait_idle(n);
    chk(r, "stop cycles", n, 1 + 4*q);
    rd(1, v); chk(r, "stop/flag bits cleared", v & (STO | FLG), 0);
    chk(r, "irq low after stop", irq, 0);
    chk(r, "lines released", {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2, v); chk("R1", "status", v, 8'hF8);
    chk("R1", "irq", irq, 0);
    chk("R1", "lines", {scl_drive_low, sda_drive_low}, 0);
    rd(1, v); chk("R1", "control", v, 0);
    rd(0, v); chk("R1", "data", v, 0);
    rd(3, v); chk("R1", "bit rate", v, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    wr(1, STA);
    repeat (100) @(posedge clk); #0.5;
    rd(2, v); chk("R12", "status unchanged", v, 8'hF8);
    chk("R12", "irq", irq, 0);
    chk("R12", "lines", {scl_drive_low, sda_drive_low}, 0);
    wr(3, 8'h00);
    rd(1, v); chk("R11", "control cleared", v, 0);
    wr(1, EN | FLG);
    repeat (20) @(posedge clk); #0.5;
    chk("R9", "flag not set by write", irq, 0);
    wr(1, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    ev_start(5, 8'h08, "R3");
    ev_byte({SLV, 1'b0}, EN, 5, 8'h18, "R5");
    ev_byte(8'h01, EN, 5, 8'h28, "R7");
    ev_byte(8'h77, EN, 5, 8'h28, "R7");
    chk("R7", "slave received byte", mem[1], 8'h77);
    repeat (300) @(posedge clk); #0.5;
    chk("R9", "flag held", irq, 1);
    chk("R9", "scl held low", scl_drive_low, 1);
    rd(2, v); chk("R9", "status held", v, 8'h28);
    ev_start(5, 8'h10, "R4");
    ev_byte({SLV, 1'b1}, EN, 5, 8'h40, "R6");
    ev_byte(8'h00, EN | ACK, 5, 8'h50, "R8");
    rd(0, v); chk("R8", "rx byte with ack", v, 8'hC3);
    ev_byte(8'h00, EN, 5, 8'h58, "R8");
    rd(0, v); chk("R8", "rx byte with nack", v, 8'h5A);
    ev_stop(5, "R10");
  endtask

  task automatic t_addr_nack;
    ev_start(5, 8'h08, "R3");
    ev_byte({7'h23, 1'b0}, EN, 5, 8'h20, "R5");
    ev_stop(5, "R10");
    ev_start(5, 8'h08, "R3");
    ev_byte({7'h23, 1'b1}, EN, 5, 8'h48, "R6");
    ev_stop(5, "R10");
  endtask

  task automatic t_data_nack;
    slv_ack_data = 0;
    ev_start(5, 8'h08, "R3");
    ev_byte({SLV, 1'b0}, EN, 5, 8'h18, "R5");
    ev_byte(8'h99, EN, 5, 8'h30, "R7");
    ev_stop(5, "R10");
    slv_ack_data = 1;
  endtask

  task automatic t_baud_srst;
    logic [7:0] v;
    wr(2, 8'h09);
    rd(3, v); chk("R2", "bit rate readback", v, 8'h09);
    ev_start(20, 8'h08, "R2");
    wr(0, {SLV, 1'b0}); wr(1, EN);
    repeat (100) @(posedge clk);
    wr(3, 8'h00);
    rd(2, v); chk("R11", "status after soft reset", v, 8'hF8);
    rd(1, v); chk("R11", "control after soft reset", v, 0);
    chk("R11", "lines after soft reset", {scl_drive_low, sda_drive_low, irq}, 0);
  endtask

  initial begin
    mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'hC3; mem[3] = 8'h5A; ptr = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(posedge clk); #0.5;
    t_reset;
    t_disabled;
    t_write_read;
    t_addr_nack;
    t_data_nack;
    t_baud_srst;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule